// File: doc/BRIEF.md
# Serial Converter Host Sequencer

This block is the host side of a link to a four-channel, ten-bit serial analog-to-digital converter that runs its conversions on its own internal clock. A client raises a one-cycle request that carries a channel number, a unipolar or bipolar coding choice, a single-ended or differential input choice and a two-bit power setting. The sequencer turns these into an eight-bit command, lowers chip select and shifts the command out on the data-in line while it generates the serial clock.

After the command it stops the serial clock. It waits for the converter's ready strobe to fall and then to rise again, and it does not count a fixed number of cycles. It then clocks out the rest of the frame, keeps the ten result bits, drops the trailing sub-bits and zero fill, raises chip select and shows the result with a one-cycle valid pulse. If the strobe does not complete its low period within a programmable number of system clocks, the sequencer reports a timeout and returns to idle.

Top module: `adc_host_ctrl`

## Requirements
- R1: After reset, `adc_cs_n` is high, `adc_sclk` is low, and `busy`, `res_valid` and `err_timeout` are low.
- R2: The command is shifted MSB first as one 8-bit word {1, req_chan[2:0], req_unipolar, req_single, req_pwr[1:0]}. The leading 1 is the start marker, and it is on `adc_din` in the cycle in which chip select falls.
- R3: While chip select is low, `adc_din` changes only in the cycle in which `adc_sclk` falls. Exactly 8 clock pulses carry the command before the clock pauses.
- R4: `adc_sclk` stays low from the end of the command until the synchronised strobe is seen high again. No rising edge of `adc_sclk` occurs while the strobe is low.
- R5: After the strobe returns high, exactly 16 more clock pulses are issued. `adc_dout` is sampled on rising edges 2 to 11 of that group, and those samples form the result MSB first. The samples on edges 12 to 16 (two sub-bits and the zero fill) are discarded.
- R6: When the frame completes, `res_valid` is high for exactly one cycle with `res_data` holding the result. In that cycle `busy` is low and `adc_cs_n` is high.
- R7: If the strobe has not fallen and risen again within `wait_limit` system clocks after the command, `err_timeout` pulses for one cycle, `res_valid` stays low, `adc_cs_n` goes high and the sequencer returns to idle. A conversion that finishes within the limit raises no error.
- R8: A request raised while `busy` is high is ignored, and only one command frame reaches the converter.
- R9: Each high phase of `adc_sclk` lasts exactly `sclk_half` system clocks, for `sclk_half` of 1 or more.
- R10: `adc_cs_n` is high whenever the sequencer is idle, and `adc_sclk` is low whenever `adc_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle conversion request, accepted only when idle |
| req_chan | input | 3 | Channel select field of the command |
| req_unipolar | input | 1 | Unipolar coding when 1, bipolar when 0 |
| req_single | input | 1 | Single-ended input when 1, differential when 0 |
| req_pwr | input | 2 | Power-mode field of the command |
| sclk_half | input | 8 | Serial clock half period in system clocks |
| wait_limit | input | 16 | Timeout for the strobe low period, in system clocks |
| busy | output | 1 | High from request acceptance to the end of the frame |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_din | output | 1 | Command data to the converter |
| adc_dout | input | 1 | Result data from the converter |
| adc_strobe | input | 1 | Converter ready strobe, low during conversion |
| res_valid | output | 1 | One-cycle result valid pulse |
| res_data | output | 10 | Conversion result |
| err_timeout | output | 1 | One-cycle pulse when the strobe wait times out |

## Verification
The hardest situations to reach from the ports are a strobe that falls and never rises, and a clock that stays parked for a long and variable conversion time. The converter model in the bench takes a per-transaction conversion delay drawn at random, so the stall lasts a different number of cycles each time. A stuck switch in the model holds the strobe low so that the timeout path runs, and a normal frame follows it to show recovery. A second request injected in the middle of a frame, together with result words whose last bits are all ones or all zeros, covers the ignore rule and the discarded trailing bits.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  localparam int CTRL_W = 8;
  localparam int CHAN_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_SEND_CTRL = 3'd1,
    ST_WAIT_LOW  = 3'd2,
    ST_WAIT_HIGH = 3'd3,
    ST_READ      = 3'd4,
    ST_DONE      = 3'd5
  } host_state_e;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic              unipolar;
    logic              single_ended;
    logic [1:0]        pwr;
  } conv_req_t;

  // Command layout: start marker first, then the request fields MSB first.
  function automatic logic [CTRL_W-1:0] pack_ctrl(input conv_req_t r);
    return {1'b1, r.chan, r.unipolar, r.single_ended, r.pwr};
  endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             rise,
  output logic             fall
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic [DIV_W-1:0] half_eff;
  logic             wrap;

  assign half_eff = (half_div == '0) ? DIV_W'(1) : half_div;
  assign wrap     = en && (({1'b0, cnt_q} + 1'b1) >= {1'b0, half_eff});

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!en) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (wrap) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;
  assign rise = wrap && !sclk_q;
  assign fall = wrap && sclk_q;

endmodule

// File: rtl/adc_shift_unit.sv
module adc_shift_unit #(
  parameter int TX_W = 8,
  parameter int RX_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TX_W-1:0] load_word,
  input  logic            tx_shift,
  input  logic            rx_sample,
  input  logic            rx_bit,
  output logic            din,
  output logic [RX_W-1:0] rx_word
);

  logic [TX_W-1:0] tx_q, tx_d;
  logic [RX_W-1:0] rx_q, rx_d;
  logic            tx_en, rx_en;

  assign tx_en = load | tx_shift;
  assign rx_en = load | rx_sample;

  always_comb begin
    tx_d = tx_q;
    if (load)          tx_d = load_word;
    else if (tx_shift) tx_d = {tx_q[TX_W-2:0], 1'b0};
  end

  always_comb begin
    rx_d = rx_q;
    if (load)           rx_d = '0;
    else if (rx_sample) rx_d = {rx_q[RX_W-2:0], rx_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tx_q <= '0;
    else if (tx_en) tx_q <= tx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rx_q <= '0;
    else if (rx_en) rx_q <= rx_d;
  end

  assign din     = tx_q[TX_W-1];
  assign rx_word = rx_q;

endmodule

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired = run && (cnt_q >= limit);
  assign cnt_en  = !run || !expired;

  always_comb begin
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int TMO_W       = 16,
  parameter int RES_W       = 10,
  parameter int READ_CLKS   = 16,
  parameter int LEAD_SKIP   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_chan,
  input  logic             req_unipolar,
  input  logic             req_single,
  input  logic [1:0]       req_pwr,
  input  logic [DIV_W-1:0] sclk_half,
  input  logic [TMO_W-1:0] wait_limit,
  output logic             busy,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_din,
  input  logic             adc_dout,
  input  logic             adc_strobe,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic             err_timeout
);

  localparam int CNT_W = $clog2(READ_CLKS + CTRL_W + 1);
  localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(CTRL_W);
  localparam logic [CNT_W-1:0] READ_LAST = CNT_W'(READ_CLKS);
  localparam logic [CNT_W-1:0] CAP_FIRST = CNT_W'(LEAD_SKIP);
  localparam logic [CNT_W-1:0] CAP_END   = CNT_W'(LEAD_SKIP + RES_W);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Strobe synchroniser, depth chosen by parameter.
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   strobe_s;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) sync_q <= 1'b1;
        else            sync_q <= adc_strobe;
      end
    end else begin : g_sync_many
      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) sync_q <= '1;
        else            sync_q <= {sync_q[SYNC_STAGES-2:0], adc_strobe};
      end
    end
  endgenerate
  assign strobe_s = sync_q[SYNC_STAGES-1];

  host_state_e state_q, state_d;
  logic [CNT_W-1:0] pcnt_q, pcnt_d;
  logic             load, tx_shift, rx_sample;
  logic             done_set, err_set;
  logic             gen_en, sclk_rise, sclk_fall, tmo_run, tmo_hit;
  logic [RES_W-1:0] rx_word;
  logic [CTRL_W-1:0] ctrl_word;
  conv_req_t        req_in;
  logic             cs_active_d;
  logic             cs_n_q, valid_q, err_q;
  logic [RES_W-1:0] res_q;

  assign req_in    = '{chan: req_chan, unipolar: req_unipolar,
                       single_ended: req_single, pwr: req_pwr};
  assign ctrl_word = pack_ctrl(req_in);
  assign gen_en    = (state_q == ST_SEND_CTRL) || (state_q == ST_READ);
  assign tmo_run   = (state_q == ST_WAIT_LOW) || (state_q == ST_WAIT_HIGH);

  adc_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en       (gen_en),
    .half_div (sclk_half),
    .sclk     (adc_sclk),
    .rise     (sclk_rise),
    .fall     (sclk_fall)
  );

  adc_shift_unit #(.TX_W(CTRL_W), .RX_W(RES_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (load),
    .load_word (ctrl_word),
    .tx_shift  (tx_shift),
    .rx_sample (rx_sample),
    .rx_bit    (adc_dout),
    .din       (adc_din),
    .rx_word   (rx_word)
  );

  adc_wait_timer #(.TMO_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (tmo_run),
    .limit   (wait_limit),
    .expired (tmo_hit)
  );

  // Next-state logic.
  always_comb begin
    state_d   = state_q;
    pcnt_d    = pcnt_q;
    load      = 1'b0;
    tx_shift  = 1'b0;
    rx_sample = 1'b0;
    done_set  = 1'b0;
    err_set   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          load    = 1'b1;
          pcnt_d  = '0;
          state_d = ST_SEND_CTRL;
        end
      end
      ST_SEND_CTRL: begin
        if (sclk_rise) pcnt_d = pcnt_q + 1'b1;
        if (sclk_fall) begin
          tx_shift = 1'b1;
          if (pcnt_q == CTRL_LAST) begin
            pcnt_d  = '0;
            state_d = ST_WAIT_LOW;
          end
        end
      end
      ST_WAIT_LOW: begin
        if (tmo_hit) begin
          err_set = 1'b1;
          state_d = ST_IDLE;
        end else if (!strobe_s) begin
          state_d = ST_WAIT_HIGH;
        end
      end
      ST_WAIT_HIGH: begin
        if (tmo_hit) begin
          err_set = 1'b1;
          state_d = ST_IDLE;
        end else if (strobe_s) begin
          pcnt_d  = '0;
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        if (sclk_rise) begin
          pcnt_d = pcnt_q + 1'b1;
          if (pcnt_q >= CAP_FIRST && pcnt_q < CAP_END) rx_sample = 1'b1;
        end
        if (sclk_fall && pcnt_q == READ_LAST) state_d = ST_DONE;
      end
      ST_DONE: begin
        done_set = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cs_active_d = (state_d == ST_SEND_CTRL) || (state_d == ST_WAIT_LOW) ||
                       (state_d == ST_WAIT_HIGH) || (state_d == ST_READ);

  // Register processes.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      pcnt_q  <= '0;
      cs_n_q  <= 1'b1;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pcnt_q  <= pcnt_d;
      cs_n_q  <= ~cs_active_d;
      valid_q <= done_set;
      err_q   <= err_set;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    res_q <= '0;
    else if (done_set) res_q <= rx_word;
  end

  assign busy        = (state_q != ST_IDLE);
  assign adc_cs_n    = cs_n_q;
  assign res_valid   = valid_q;
  assign res_data    = res_q;
  assign err_timeout = err_q;

endmodule

// File: rtl/adc_host_ctrl_chk.sv
module adc_host_ctrl_chk
  import adc_host_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        adc_cs_n,
  input logic        adc_sclk,
  input logic        adc_din,
  input logic        adc_strobe,
  input logic        res_valid,
  input logic        err_timeout,
  input host_state_e state
);

  assert_start_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> adc_din);

  assert_din_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n && $past(!adc_cs_n) && (adc_din != $past(adc_din)))
      |-> ($past(adc_sclk) && !adc_sclk));

  assert_parked_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WAIT_LOW) || (state == ST_WAIT_HIGH)) |-> !adc_sclk);

  assert_no_clock_in_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_strobe && !adc_cs_n) |-> !adc_sclk);

  assert_single_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_valid_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (!busy && adc_cs_n));

  assert_timeout_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (!busy && adc_cs_n && !res_valid));

  assert_idle_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> adc_cs_n);

  assert_cs_clock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);

endmodule

bind adc_host_ctrl adc_host_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .adc_cs_n    (adc_cs_n),
  .adc_sclk    (adc_sclk),
  .adc_din     (adc_din),
  .adc_strobe  (adc_strobe),
  .res_valid   (res_valid),
  .err_timeout (err_timeout),
  .state       (state_q)
);

// File: tb/adc_host_ctrl_test.sv
`timescale 1ns/1ps
module adc_host_ctrl_test;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_chan;
  logic       req_unipolar;
  logic       req_single;
  logic [1:0] req_pwr;
  logic [7:0] sclk_half;
  logic [15:0] wait_limit;
  logic       busy;
  logic       adc_cs_n;
  logic       adc_sclk;
  logic       adc_din;
  logic       adc_dout;
  logic       adc_strobe;
  logic       res_valid;
  logic [9:0] res_data;
  logic       err_timeout;

  int checks = 0;
  int errors = 0;

  adc_host_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .req_unipolar(req_unipolar), .req_single(req_single), .req_pwr(req_pwr),
    .sclk_half(sclk_half), .wait_limit(wait_limit), .busy(busy),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din),
    .adc_dout(adc_dout), .adc_strobe(adc_strobe), .res_valid(res_valid),
    .res_data(res_data), .err_timeout(err_timeout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Converter model and link monitor, evaluated on the falling system clock edge.
  logic       m_sclk_p, m_cs_p, m_din_p;
  int         m_bits, m_phase, m_left;
  logic [7:0] m_word;
  logic [15:0] m_osr;
  int         m_conv;
  logic [9:0] m_result;
  bit         m_stuck;
  logic [7:0] cap_word;
  int         frames, rises_total, rises_low, din_bad, half_bad, hi_run, exp_div;

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_strobe = 1'b1; adc_dout = 1'b0;
      m_sclk_p = 1'b0; m_cs_p = 1'b1; m_din_p = 1'b0;
      m_bits = 0; m_phase = 0; m_left = 0; m_word = '0; m_osr = '0;
      hi_run = 0;
    end else begin
      if (m_phase == 1 && !m_stuck) begin
        if (m_left <= 1) begin
          adc_strobe = 1'b1; m_phase = 2;
          m_osr = {m_result, 2'b11, 4'b0000};
        end else m_left = m_left - 1;
      end
      if (!adc_cs_n && m_cs_p) begin m_bits = 0; m_phase = 0; m_word = '0; end
      if (adc_cs_n && !m_cs_p && m_stuck) begin adc_strobe = 1'b1; m_phase = 0; end
      if (!adc_cs_n) begin
        if (adc_sclk && !m_sclk_p) begin
          rises_total++;
          if (!adc_strobe) rises_low++;
          if (m_phase == 0 && m_bits < 8) begin
            m_word = {m_word[6:0], adc_din}; m_bits++;
          end
        end
        if (!adc_sclk && m_sclk_p) begin
          if (m_phase == 0 && m_bits == 8) begin
            m_phase = 1; m_bits = 9; adc_strobe = 1'b0; m_left = m_conv;
            frames++; cap_word = m_word;
          end else if (m_phase == 2) begin
            adc_dout = m_osr[15]; m_osr = {m_osr[14:0], 1'b0};
          end
        end
        if (!m_cs_p && (adc_din !== m_din_p) && !(!adc_sclk && m_sclk_p)) din_bad++;
      end
      if (adc_sclk) hi_run++;
      else if (m_sclk_p) begin
        if (hi_run != exp_div) half_bad++;
        hi_run = 0;
      end
      m_sclk_p = adc_sclk; m_cs_p = adc_cs_n; m_din_p = adc_din;
    end
  end

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_word(input logic [2:0] ch, input logic uni,
                                          input logic sgl, input logic [1:0] pd);
    return {1'b1, ch, uni, sgl, pd};
  endfunction

  task automatic run_txn(input logic [2:0] ch, input logic uni, input logic sgl,
                         input logic [1:0] pd, input int div, input int conv,
                         input logic [9:0] res, input bit stuck, input bit poke);
    int got_v = 0, got_e = 0, busy_cyc = 0;
    logic [9:0] got_d = '0;
    bit ended = 0;
    step();
    sclk_half = 8'(div); exp_div = div; m_conv = conv; m_result = res; m_stuck = stuck;
    frames = 0; rises_total = 0; rises_low = 0; din_bad = 0; half_bad = 0;
    cap_word = '0;
    req_valid = 1'b1; req_chan = ch; req_unipolar = uni; req_single = sgl; req_pwr = pd;
    step();
    req_valid = 1'b0;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      if (poke && cyc == 40) begin req_valid = 1'b1; req_chan = ch ^ 3'b011; end
      else req_valid = 1'b0;
      if (busy) busy_cyc++;
      if (res_valid) begin got_v++; got_d = res_data; end
      if (err_timeout) got_e++;
      if (!busy) begin ended = 1; break; end
      step();
    end
    req_valid = 1'b0;
    chk(ended, "R7", "frame never ended", 0, 1);
    step();
    chk(adc_cs_n == 1'b1, "R10", "cs_n after frame", int'(adc_cs_n), 1);
    chk(res_valid == 1'b0, "R6", "valid longer than one cycle", int'(res_valid), 0);
    if (stuck) begin
      chk(got_e == 1, "R7", "timeout pulses", got_e, 1);
      chk(got_v == 0, "R7", "valid after timeout", got_v, 0);
      chk(busy_cyc > int'(wait_limit), "R7", "timeout too early", busy_cyc, int'(wait_limit));
    end else begin
      chk(cap_word == exp_word(ch, uni, sgl, pd), "R2", "command word",
          int'(cap_word), int'(exp_word(ch, uni, sgl, pd)));
      chk(got_v == 1, "R6", "valid pulses", got_v, 1);
      chk(got_d == res, "R5", "result", int'(got_d), int'(res));
      chk(rises_total == 24, "R5", "clock pulses in frame", rises_total, 24);
      chk(got_e == 0, "R7", "spurious timeout", got_e, 0);
      chk(rises_low == 0, "R4", "clock during conversion", rises_low, 0);
      chk(din_bad == 0, "R3", "din changed off falling edge", din_bad, 0);
      chk(half_bad == 0, "R9", "high phase length", half_bad, 0);
    end
    if (poke) chk(frames == 1, "R8", "frames for busy request", frames, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    rst_n = 1'b0; req_valid = 1'b0; req_chan = '0; req_unipolar = 1'b0;
    req_single = 1'b0; req_pwr = '0; sclk_half = 8'd2; wait_limit = 16'd500;
    m_conv = 10; m_result = '0; m_stuck = 0; exp_div = 2;
    frames = 0; rises_total = 0; rises_low = 0; din_bad = 0; half_bad = 0; cap_word = '0;
    repeat (4) @(posedge clk);
    #5 rst_n = 1'b1;
    step(); step(); step();
    // R1 reset state
    chk(adc_cs_n == 1'b1, "R1", "cs_n", int'(adc_cs_n), 1);
    chk(adc_sclk == 1'b0, "R1", "sclk", int'(adc_sclk), 0);
    chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
    chk(res_valid == 1'b0 && err_timeout == 1'b0, "R1", "valid/err",
        int'({res_valid, err_timeout}), 0);

    // Directed corners.
    run_txn(3'd5, 1'b1, 1'b1, 2'b11, 1, 40, 10'h3FF, 0, 0);
    run_txn(3'd0, 1'b0, 1'b0, 2'b00, 2, 8, 10'h000, 0, 0);
    run_txn(3'd7, 1'b0, 1'b1, 2'b01, 7, 150, 10'h200, 0, 0);
    run_txn(3'd2, 1'b1, 1'b0, 2'b10, 3, 100, 10'h155, 0, 1);

    // Random transactions.
    for (int i = 0; i < 14; i++) begin
      run_txn(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
              int'($urandom_range(1, 5)), int'($urandom_range(5, 200)),
              10'($urandom_range(0, 1023)), 0, 0);
    end

    // Strobe stuck low, then recovery.
    wait_limit = 16'd300;
    run_txn(3'd1, 1'b1, 1'b1, 2'b11, 2, 50, 10'h0AA, 1, 0);
    wait_limit = 16'd500;
    run_txn(3'd6, 1'b0, 1'b1, 2'b10, 2, 60, 10'h2C3, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule